// File: doc/BRIEF.md
# Eight-Output Addressable Latch

This block holds eight single-bit storage elements behind one shared data input. A 3-bit address picks the element that the data input may reach. Two active-low controls, a write enable and a clear, together pick one of four modes. The same address and data inputs can therefore act as a 1-to-8 demultiplexer, as a bit-addressable register, as a frozen register, or as a wholesale clear.

The block is synchronous. Every mode takes effect on the rising edge of the system clock. The stored state after each edge equals what a transparent latch would show with the same inputs held at that moment. A synchronous active-low reset clears all eight bits. The block is used where a narrow serial-style control path must set or clear individual lines of a wider control word one at a time.

Top module: `addr_latch8`

## Requirements
- R1: While `rst_n` is low at a rising edge, all eight bits of `q` are 0 after that edge.
- R2: Demultiplexer mode (`wr_en_n`=0, `clr_n`=0): after the edge, `q[addr]` equals `din` and every other bit of `q` is 0.
- R3: Addressable latch mode (`wr_en_n`=0, `clr_n`=1): after the edge, `q[addr]` equals `din` and every other bit keeps its previous value.
- R4: When the address changes while `wr_en_n` stays low, the newly addressed bit takes `din`. The previously addressed bit keeps its last written value in addressable latch mode and becomes 0 in demultiplexer mode.
- R5: Memory mode (`wr_en_n`=1, `clr_n`=1): `q` is unchanged by the edge, whatever `din` and `addr` are.
- R6: Clear mode (`wr_en_n`=1, `clr_n`=0): all eight bits of `q` are 0 after the edge.
- R7: After clear mode is followed by memory mode, `q` stays all zero until `wr_en_n` goes low again.
- R8: Address value n, for n from 0 to 7, selects bit n of `q` (binary, bit 0 is the least significant bit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_n | input | 1 | Active-low write enable |
| clr_n | input | 1 | Active-low clear control |
| addr | input | 3 | Index of the bit that `din` may reach |
| din | input | 1 | Shared data input |
| q | output | 8 | Stored bits, one per address |

## Verification
The assertions assume that `wr_en_n`, `clr_n`, `addr` and `din` are known, non-X values at every rising edge once reset has been released. They also assume these inputs are stable across the edge. The stimulus meets this by changing every input only on the falling clock edge, from time zero, with no input ever left undriven. Each mode is entered with all eight addresses, and in-mode address moves and every mode-to-mode transition are included. Random input sequences then mix the modes freely against a reference model of the four-mode table.

// File: rtl/addr_latch_pkg.sv
// Package: shared mode type and control decoding for the addressable latch.
// Assumes the two controls are active low; every combination is a defined mode.
package addr_latch_pkg;

    typedef enum logic [1:0] {
        MODE_DEMUX = 2'b00,   // write on, clear on: one-hot data, rest zero
        MODE_LATCH = 2'b01,   // write on, clear off: update addressed bit only
        MODE_CLEAR = 2'b10,   // write off, clear on: all bits zero
        MODE_HOLD  = 2'b11    // write off, clear off: keep everything
    } alm_mode_e;

    // Map the raw active-low control pair onto a mode.
    function automatic alm_mode_e to_mode(input logic wr_en_n, input logic clr_n);
        alm_mode_e m;
        case ({wr_en_n, clr_n})
            2'b00:   m = MODE_DEMUX;
            2'b01:   m = MODE_LATCH;
            2'b10:   m = MODE_CLEAR;
            default: m = MODE_HOLD;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/alm_mode_decode.sv
// Module: alm_mode_decode
// Turns the two active-low control inputs into one mode value.
// Assumes nothing about timing; purely combinational.
module alm_mode_decode
    import addr_latch_pkg::*;
(
    input  logic      wr_en_n,
    input  logic      clr_n,
    output alm_mode_e mode
);

    // Purpose: combinational mode selection.
    always_comb begin
        mode = to_mode(wr_en_n, clr_n);
    end

endmodule

// File: rtl/alm_addr_decode.sv
// Module: alm_addr_decode
// Binary-to-one-hot decoder: output bit n is high when addr equals n.
// Assumes WIDTH = 2**ADDR_W so every address maps to a bit.
module alm_addr_decode #(
    parameter int ADDR_W = 3,
    localparam int WIDTH = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [WIDTH-1:0]  sel
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_sel
        // Purpose: compare address against this bit's index.
        always_comb begin
            sel[i] = (addr == ADDR_W'(i));
        end
    end

endmodule

// File: rtl/alm_bit_cell.sv
// Module: alm_bit_cell
// One storage bit. Its next value depends on the mode and on whether
// this bit is the addressed one. Synchronous active-low reset.
// Assumes mode and sel are settled before the rising edge.
module alm_bit_cell
    import addr_latch_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  alm_mode_e mode,
    input  logic      sel,
    input  logic      din,
    output logic      q
);

    logic q_next;

    // Purpose: compute the value this bit takes at the next edge.
    always_comb begin
        case (mode)
            MODE_DEMUX: q_next = sel ? din : 1'b0;
            MODE_LATCH: q_next = sel ? din : q;
            MODE_CLEAR: q_next = 1'b0;
            default:    q_next = q;
        endcase
    end

    // Purpose: store the bit, clearing it on synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            q <= q_next;
        end
    end

endmodule

// File: rtl/addr_latch8.sv
// Module: addr_latch8 (top)
// Eight-output addressable latch modelled synchronously. The controls
// wr_en_n and clr_n pick demux, addressable latch, hold or clear mode.
// Assumes inputs are stable around each rising clock edge.
module addr_latch8
    import addr_latch_pkg::*;
#(
    parameter int ADDR_W = 3,
    localparam int WIDTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_n,
    input  logic              clr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic [WIDTH-1:0]  q
);

    alm_mode_e        mode;
    logic [WIDTH-1:0] sel;

    alm_mode_decode u_mode (
        .wr_en_n (wr_en_n),
        .clr_n   (clr_n),
        .mode    (mode)
    );

    alm_addr_decode #(.ADDR_W(ADDR_W)) u_addr (
        .addr (addr),
        .sel  (sel)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        alm_bit_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (mode),
            .sel   (sel[i]),
            .din   (din),
            .q     (q[i])
        );
    end

endmodule

// File: rtl/addr_latch8_chk.sv
// Module: addr_latch8_chk
// Assertion checker bound to addr_latch8. Relates ports across one edge.
// Assumes inputs are known at each rising edge after reset release.
module addr_latch8_chk #(
    parameter int ADDR_W = 3,
    localparam int WIDTH = 1 << ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_n,
    input logic              clr_n,
    input logic [ADDR_W-1:0] addr,
    input logic              din,
    input logic [WIDTH-1:0]  q
);

    // R1: reset clears every bit
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (q == '0));

    // R2: demux mode leaves at most the addressed bit set, carrying din
    a_r2_demux_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_n && !clr_n) |=> ($countones(q) <= 1) && (q[$past(addr)] == $past(din)));

    // R3, R8: latch mode writes bit addr
    a_r3_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_n && clr_n) |=> (q[$past(addr)] == $past(din)));

    // R3: latch mode leaves unaddressed bits alone
    a_r3_latch_others: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_n && clr_n) |=>
        ((q & ~(WIDTH'(1) << $past(addr))) == ($past(q) & ~(WIDTH'(1) << $past(addr)))));

    // R5: memory mode freezes the outputs
    a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_n && clr_n) |=> $stable(q));

    // R6: clear mode zeroes the outputs
    a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_n && !clr_n) |=> (q == '0));

endmodule

bind addr_latch8 addr_latch8_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_n (wr_en_n),
    .clr_n   (clr_n),
    .addr    (addr),
    .din     (din),
    .q       (q)
);

// File: tb/sim_addr_latch8.sv
// Scoreboard bench: a driver task applies one cycle of inputs on the falling
// edge and queues the expected output; a monitor pops it after the next rise.
module sim_addr_latch8;

    localparam int AW = 3;
    localparam int W  = 1 << AW;

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } exp_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en_n = 1'b1;
    logic          clr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          din = 1'b0;
    logic [W-1:0]  q;

    logic [W-1:0]  model = '0;
    exp_item_t     sb[$];
    int            n_run = 0;
    int            n_fail = 0;
    bit            finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    addr_latch8 #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .clr_n(clr_n),
        .addr(addr), .din(din), .q(q)
    );

    // Reference model of the four-mode table plus reset.
    function automatic logic [W-1:0] next_q(input logic [W-1:0] cur, input logic rn,
                                            input logic we, input logic cl,
                                            input logic [AW-1:0] a, input logic d);
        logic [W-1:0] n;
        n = cur;
        if (!rn) n = '0;
        else case ({we, cl})
            2'b00: begin n = '0; n[a] = d; end
            2'b01: n[a] = d;
            2'b10: n = '0;
            default: n = cur;
        endcase
        return n;
    endfunction

    // Driver: one cycle of stimulus, expected value queued.
    task automatic step(input logic rn, input logic we, input logic cl,
                        input logic [AW-1:0] a, input logic d, input string tag);
        exp_item_t it;
        @(negedge clk);
        rst_n = rn; wr_en_n = we; clr_n = cl; addr = a; din = d;
        model = next_q(model, rn, we, cl, a, d);
        it.exp = model;
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compare after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_item_t it;
                it = sb.pop_front();
                n_run++;
                if (q !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: q=%b expected=%b", it.tag, q, it.exp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #1000000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with data inputs active
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1, AW'(i), 1'b1, "R1 reset");

        // R3, R8: set each bit in latch mode, accumulating
        for (int a = 0; a < W; a++) step(1'b1, 1'b0, 1'b1, AW'(a), 1'b1, "R3/R8 latch set");
        // R3: clear alternate bits
        for (int a = 0; a < W; a += 2) step(1'b1, 1'b0, 1'b1, AW'(a), 1'b0, "R3 latch clear");

        // R5: hold while din and addr move
        for (int a = 0; a < W; a++) step(1'b1, 1'b1, 1'b1, AW'(a), a[0], "R5 hold");

        // R2, R8: demux sweep with data 1 then 0
        for (int a = 0; a < W; a++) step(1'b1, 1'b0, 1'b0, AW'(a), 1'b1, "R2/R8 demux one");
        for (int a = 0; a < W; a++) step(1'b1, 1'b0, 1'b0, AW'(a), 1'b0, "R2 demux zero");

        // R4: address moves under latch mode then demux mode
        step(1'b1, 1'b0, 1'b1, 3'd2, 1'b1, "R4 latch first");
        step(1'b1, 1'b0, 1'b1, 3'd5, 1'b1, "R4 latch moved");
        step(1'b1, 1'b0, 1'b1, 3'd7, 1'b0, "R4 latch moved again");
        step(1'b1, 1'b0, 1'b0, 3'd3, 1'b1, "R4 demux first");
        step(1'b1, 1'b0, 1'b0, 3'd6, 1'b1, "R4 demux moved");

        // R6 then R7: fill, clear, hold with data present
        for (int a = 0; a < W; a++) step(1'b1, 1'b0, 1'b1, AW'(a), 1'b1, "R6 prefill");
        step(1'b1, 1'b1, 1'b0, 3'd4, 1'b1, "R6 clear");
        for (int a = 0; a < W; a++) step(1'b1, 1'b1, 1'b1, AW'(a), 1'b1, "R7 hold after clear");
        step(1'b1, 1'b0, 1'b1, 3'd1, 1'b1, "R7 enable again");

        // R5/R6 in every address during clear
        for (int a = 0; a < W; a++) step(1'b1, 1'b1, 1'b0, AW'(a), 1'b1, "R6 clear sweep");

        // Mixed random sequence across all modes, plus a mid-run reset.
        for (int i = 0; i < 400; i++) begin
            logic [3:0] r;
            r = 4'($urandom_range(0, 15));
            step((i == 200) ? 1'b0 : 1'b1, r[0], r[1], AW'($urandom_range(0, W-1)),
                 r[2], (i == 200) ? "R1 mid reset" : "R2/R3/R5/R6 mixed");
        end

        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule